// File: doc/BRIEF.md
# Filtered Input-Capture Timer

This block is a 16-bit up-counter paired with an input-capture unit. A single external capture pin is synchronized into the clock domain. It can then be passed through a four-sample agreement filter, and after that through an edge detector that reacts to either rising or falling transitions. When a qualifying edge arrives, the current count is copied into the capture register and a capture flag is raised. The counter advances only on cycles where the count-enable tick is high. It either runs freely up to full scale or clears when it matches the capture register, which then acts as its top value. In the clear-on-match mode the capture pin is ignored, so the top value cannot be overwritten by a capture.

Software reaches the block through a plain write strobe with an address and write data, and through a combinational read port. Five locations are decoded:

- address 0, control: bit 0 enables the filter, bit 1 selects the rising edge (0 selects falling), bit 2 selects clear-on-match.
- address 1, interrupt enable: bit 0 enables the capture interrupt, bit 1 the overflow interrupt.
- address 2, flags: bit 0 is the capture flag and bit 1 the overflow flag, each cleared by writing 1.
- address 3, count.
- address 4, capture register.

The filter is a state machine with eight states:
- FLT_LO and FLT_HI are the settled low and high states.
- FLT_RISE1 to FLT_RISE3 count the agreeing high samples seen while settled low. Each high sample advances one step, FLT_RISE3 moves to FLT_HI on a high sample, and any low sample returns to FLT_LO.
- FLT_FALL1 to FLT_FALL3 mirror this on the way down and return to FLT_HI on any high sample.
- The filtered level is high in FLT_HI and in the three FLT_FALL states.

Top module: `capture_timer`

## Requirements
- R1: After reset every register reads 0 and both interrupt outputs are low; control bits 15:3, enable bits 15:2 and flag bits 15:2 always read 0, even after writing all ones.
- R2: In free-running mode (control bit 2 = 0) the count advances by one on each cycle with tick high and holds otherwise. A tick at 0xFFFF wraps the count to 0 and sets the overflow flag (flag bit 1).
- R3: In clear-on-match mode (control bit 2 = 1) a tick while the count equals the capture register returns the count to 0 without setting the overflow flag. A count above that top still runs to 0xFFFF and wraps with the overflow flag set.
- R4: With the filter off and rising edges selected, a rising pin change made between edges sets the capture flag (flag bit 0) on the third clock edge. The capture register then holds the count present just before that edge.
- R5: With control bit 1 = 0 only falling edges capture and rising edges are ignored; with bit 1 = 1 the reverse holds.
- R6: With the filter on (control bit 0 = 1) the filtered level changes only after four consecutive equal synchronized samples. A pulse of three cycles produces no capture, a pulse of four cycles does, and captures occur four cycles later than on the unfiltered path.
- R7: In clear-on-match mode pin edges neither change the capture register nor set the capture flag.
- R8: Writing 1 to a flag bit clears it and writing 0 leaves it unchanged. A hardware set in the same cycle as a clear leaves the flag set.
- R9: The capture interrupt output equals capture flag AND enable bit 0; the overflow interrupt output equals overflow flag AND enable bit 1.
- R10: A write to the count takes effect on the next edge, even when tick is high. The capture register can be written by software in free-running mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable for this cycle |
| cap_pin | input | 1 | Asynchronous capture input |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr (combinational) |
| irq_cap | output | 1 | Capture interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
The hardest case is the exact cycle on which a capture lands, because the delay of the synchronizer, the filter and the edge detector shows up only as which count value gets latched. The bench keeps tick high and reads the count at the moment it moves the pin. It then expects the captured value to be that count plus 2 without the filter and plus 6 with it, under a randomly chosen filter setting and edge polarity. Directed pulses of three and four cycles probe the filter's agreement boundary. A flag clear is timed onto the very cycle of an overflow wrap to test set-over-clear priority.

// File: rtl/capture_timer_pkg.sv
package capture_timer_pkg;

    localparam int CNT_W  = 16;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADR_CTRL  = 3'd0,
        ADR_IRQEN = 3'd1,
        ADR_FLAGS = 3'd2,
        ADR_COUNT = 3'd3,
        ADR_CAPT  = 3'd4
    } reg_addr_e;

    typedef enum logic [3:0] {
        FLT_LO,
        FLT_RISE1,
        FLT_RISE2,
        FLT_RISE3,
        FLT_HI,
        FLT_FALL1,
        FLT_FALL2,
        FLT_FALL3
    } flt_state_e;

    // control and flag bit positions
    localparam int CTRL_FILT  = 0;
    localparam int CTRL_RISE  = 1;
    localparam int CTRL_MATCH = 2;
    localparam int CTRL_W     = 3;
    localparam int FLG_CAP    = 0;
    localparam int FLG_OVF    = 1;
    localparam int FLG_W      = 2;

endpackage

// File: rtl/ct_filter.sv
module ct_filter
    import capture_timer_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic filt_en,
    output logic level
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   samp;
    flt_state_e             state_q, state_d;
    logic                   filt_lvl;

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
    end

    assign samp = sync_q[SYNC_STAGES-1];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLT_LO;
        else        state_q <= state_d;
    end

    // next state: four agreeing samples are needed to change level
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLT_LO:    state_d = samp ? FLT_RISE1 : FLT_LO;
            FLT_RISE1: state_d = samp ? FLT_RISE2 : FLT_LO;
            FLT_RISE2: state_d = samp ? FLT_RISE3 : FLT_LO;
            FLT_RISE3: state_d = samp ? FLT_HI    : FLT_LO;
            FLT_HI:    state_d = samp ? FLT_HI    : FLT_FALL1;
            FLT_FALL1: state_d = samp ? FLT_HI    : FLT_FALL2;
            FLT_FALL2: state_d = samp ? FLT_HI    : FLT_FALL3;
            FLT_FALL3: state_d = samp ? FLT_HI    : FLT_LO;
            default:   state_d = FLT_LO;
        endcase
    end

    // output process
    always_comb begin
        unique case (state_q)
            FLT_HI, FLT_FALL1, FLT_FALL2, FLT_FALL3: filt_lvl = 1'b1;
            default:                                 filt_lvl = 1'b0;
        endcase
        level = filt_en ? filt_lvl : samp;
    end

    // R6: filtered level rises only after four high samples
    assert_four_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(filt_lvl) |-> ($past(samp, 1) && $past(samp, 2) &&
                             $past(samp, 3) && $past(samp, 4)));

    // R6: filtered level falls only after four low samples
    assert_four_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(filt_lvl) |-> (!$past(samp, 1) && !$past(samp, 2) &&
                             !$past(samp, 3) && !$past(samp, 4)));

endmodule

// File: rtl/ct_edge.sv
module ct_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic rise_sel,
    input  logic disconnect,
    output logic cap_evt
);

    logic prev_q;
    logic rise, fall;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    always_comb begin
        rise    = level & ~prev_q;
        fall    = ~level & prev_q;
        cap_evt = (rise_sel ? rise : fall) & ~disconnect;
    end

    // R5: an event always coincides with a level change of the selected direction
    assert_edge_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |-> (level == rise_sel) && (prev_q != level));

endmodule

// File: rtl/ct_counter.sv
module ct_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] top,
    output logic [W-1:0] count,
    output logic         ovf_evt
);

    localparam logic [W-1:0] MAX_VAL = '1;

    always_ff @(posedge clk) begin
        if (!rst_n)            count <= '0;
        else if (load)         count <= load_val;
        else if (tick)         count <= (count == top) ? '0 : count + 1'b1;
    end

    assign ovf_evt = tick & ~load & (count == MAX_VAL);

    // R2: no tick and no load means the count holds
    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(count));

    // R3: a tick at the top value returns the count to zero
    assert_wrap_at_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && count == top) |=> (count == '0));

    // R10: a software load wins over a tick
    assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_val)));

endmodule

// File: rtl/capture_timer.sv
module capture_timer
    import capture_timer_pkg::*;
#(
    parameter int W           = CNT_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cap_pin,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata,
    output logic              irq_cap,
    output logic              irq_ovf
);

    localparam logic [W-1:0] FULL_SCALE = '1;

    logic [CTRL_W-1:0] ctrl_q;
    logic [FLG_W-1:0]  ie_q;
    logic [FLG_W-1:0]  flg_q, flg_d;
    logic [W-1:0]      cap_q;
    logic [W-1:0]      count;
    logic [W-1:0]      top;
    logic              level, cap_evt, ovf_evt;
    logic              wr_ctrl, wr_ie, wr_flg, wr_cnt, wr_cap;
    logic              match_mode;

    always_comb begin
        wr_ctrl = wr_en && (addr == ADR_CTRL);
        wr_ie   = wr_en && (addr == ADR_IRQEN);
        wr_flg  = wr_en && (addr == ADR_FLAGS);
        wr_cnt  = wr_en && (addr == ADR_COUNT);
        wr_cap  = wr_en && (addr == ADR_CAPT);
    end

    assign match_mode = ctrl_q[CTRL_MATCH];
    assign top        = match_mode ? cap_q : FULL_SCALE;

    ct_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (cap_pin),
        .filt_en (ctrl_q[CTRL_FILT]),
        .level   (level)
    );

    ct_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (level),
        .rise_sel   (ctrl_q[CTRL_RISE]),
        .disconnect (match_mode),
        .cap_evt    (cap_evt)
    );

    ct_counter #(.W(W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (wr_cnt),
        .load_val (wdata),
        .top      (top),
        .count    (count),
        .ovf_evt  (ovf_evt)
    );

    // control and enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ie_q   <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= wdata[CTRL_W-1:0];
            if (wr_ie)   ie_q   <= wdata[FLG_W-1:0];
        end
    end

    // capture register: hardware capture beats a software write
    always_ff @(posedge clk) begin
        if (!rst_n)       cap_q <= '0;
        else if (cap_evt) cap_q <= count;
        else if (wr_cap)  cap_q <= wdata;
    end

    // flags: write-one-to-clear, hardware set wins
    always_comb begin
        flg_d[FLG_CAP] = cap_evt | (flg_q[FLG_CAP] & ~(wr_flg & wdata[FLG_CAP]));
        flg_d[FLG_OVF] = ovf_evt | (flg_q[FLG_OVF] & ~(wr_flg & wdata[FLG_OVF]));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign irq_cap = flg_q[FLG_CAP] & ie_q[FLG_CAP];
    assign irq_ovf = flg_q[FLG_OVF] & ie_q[FLG_OVF];

    always_comb begin
        rdata = '0;
        case (addr)
            ADR_CTRL:  rdata[CTRL_W-1:0] = ctrl_q;
            ADR_IRQEN: rdata[FLG_W-1:0]  = ie_q;
            ADR_FLAGS: rdata[FLG_W-1:0]  = flg_q;
            ADR_COUNT: rdata             = count;
            ADR_CAPT:  rdata             = cap_q;
            default:   rdata             = '0;
        endcase
    end

    // R7: in clear-on-match mode the capture register changes only by software
    assert_no_capture_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (match_mode && !wr_cap) |=> $stable(cap_q));

    // R8: a clear with no concurrent set empties the capture flag
    assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flg && wdata[FLG_CAP] && !cap_evt) |=> !flg_q[FLG_CAP]);

    // R8: an overflow always leaves the flag set, whatever software writes
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> flg_q[FLG_OVF]);

    // R4: a capture loads the count seen in the event cycle
    assert_capture_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (cap_q == $past(count)) && flg_q[FLG_CAP]);

endmodule

// File: tb/capture_timer_test.sv
module capture_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        cap_pin = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        irq_cap, irq_ovf;

    int checks = 0;
    int fails  = 0;

    localparam logic [2:0] A_CTRL = 3'd0, A_IE = 3'd1, A_FLG = 3'd2,
                           A_CNT = 3'd3, A_CAP = 3'd4;

    capture_timer uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cap_pin(cap_pin),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq_cap(irq_cap), .irq_ovf(irq_ovf)
    );

    always #10 clk = ~clk;

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] exp_cap(input logic [15:0] c, input bit filt);
        return c + (filt ? 16'd6 : 16'd2);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : main
        logic [15:0] v, c;
        void'($urandom(32'd4242));
        cycles(3);
        rst_n = 1'b1;
        cycles(1);

        // R1 reset state and reserved bits
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            chk("R1 reset value", v, 16'h0000);
        end
        chk("R1 irq_cap reset", {15'd0, irq_cap}, 16'd0);
        chk("R1 irq_ovf reset", {15'd0, irq_ovf}, 16'd0);
        wr(A_CTRL, 16'hFFFF); rd(A_CTRL, v); chk("R1 ctrl reserved", v, 16'h0007);
        wr(A_IE, 16'hFFFF);   rd(A_IE, v);   chk("R1 ie reserved", v, 16'h0003);
        wr(A_CTRL, 16'h0000); wr(A_IE, 16'h0000);

        // R10 count and capture writes
        tick = 1'b1;
        wr(A_CNT, 16'h1234); rd(A_CNT, v); chk("R10 count load beats tick", v, 16'h1234);
        cycles(1); rd(A_CNT, v); chk("R2 count advances on tick", v, 16'h1235);
        wr(A_CAP, 16'hBEEF); rd(A_CAP, v); chk("R10 capture write", v, 16'hBEEF);

        // R2 free-running wrap and R9 overflow gating
        tick = 1'b0;
        wr(A_FLG, 16'h0003);
        wr(A_CNT, 16'hFFFD);
        cycles(3); rd(A_CNT, v); chk("R2 hold without tick", v, 16'hFFFD);
        tick = 1'b1;
        cycles(2); rd(A_CNT, v); chk("R2 reach max", v, 16'hFFFF);
        rd(A_FLG, v); chk("R2 no overflow before wrap", v, 16'h0000);
        cycles(1); tick = 1'b0;
        rd(A_CNT, v); chk("R2 wrap to zero", v, 16'h0000);
        rd(A_FLG, v); chk("R2 overflow flag", v, 16'h0002);
        chk("R9 irq_ovf masked", {15'd0, irq_ovf}, 16'd0);
        wr(A_IE, 16'h0002); #1;
        chk("R9 irq_ovf enabled", {15'd0, irq_ovf}, 16'd1);
        wr(A_IE, 16'h0000);

        // R8 write 0 no effect, write 1 clears, set beats clear
        wr(A_FLG, 16'h0000); rd(A_FLG, v); chk("R8 write zero keeps flag", v, 16'h0002);
        wr(A_FLG, 16'h0002); rd(A_FLG, v); chk("R8 write one clears", v, 16'h0000);
        wr(A_CNT, 16'hFFFE);
        tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b1; addr = A_FLG; wdata = 16'h0002;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        rd(A_FLG, v); chk("R8 set wins over clear", v, 16'h0002);
        wr(A_FLG, 16'h0003);

        // R4 exact capture cycle, unfiltered rising
        wr(A_CTRL, 16'h0002);
        wr(A_CNT, 16'h0100);
        cap_pin = 1'b1;
        cycles(2); rd(A_FLG, v); chk("R4 no flag before third edge", v, 16'h0000);
        cycles(1); rd(A_FLG, v); chk("R4 flag on third edge", v, 16'h0001);
        rd(A_CAP, v); chk("R4 captured count", v, 16'h0100);
        chk("R9 irq_cap masked", {15'd0, irq_cap}, 16'd0);
        wr(A_IE, 16'h0001); #1;
        chk("R9 irq_cap enabled", {15'd0, irq_cap}, 16'd1);
        wr(A_IE, 16'h0000);
        cap_pin = 1'b0; cycles(8);
        rd(A_FLG, v); chk("R5 falling ignored when rising selected", v, 16'h0001);
        wr(A_FLG, 16'h0003);

        // R6 exact capture cycle, filtered
        wr(A_CTRL, 16'h0003);
        cap_pin = 1'b1;
        cycles(6); rd(A_FLG, v); chk("R6 no flag before seventh edge", v, 16'h0000);
        cycles(1); rd(A_FLG, v); chk("R6 flag on seventh edge", v, 16'h0001);
        cap_pin = 1'b0; cycles(10);
        wr(A_FLG, 16'h0003);

        // R6 three-cycle pulse rejected, four-cycle pulse accepted
        cap_pin = 1'b1; cycles(3); cap_pin = 1'b0; cycles(10);
        rd(A_FLG, v); chk("R6 three-cycle pulse rejected", v, 16'h0000);
        cap_pin = 1'b1; cycles(4); cap_pin = 1'b0; cycles(10);
        rd(A_FLG, v); chk("R6 four-cycle pulse accepted", v, 16'h0001);
        wr(A_FLG, 16'h0003);

        // R3 clear-on-match and R7 disconnect
        tick = 1'b0;
        wr(A_CTRL, 16'h0000);
        wr(A_CAP, 16'h0005);
        wr(A_CTRL, 16'h0006);
        wr(A_CNT, 16'h0000);
        tick = 1'b1;
        cycles(5); rd(A_CNT, v); chk("R3 reach top", v, 16'h0005);
        cycles(1); rd(A_CNT, v); chk("R3 clear on match", v, 16'h0000);
        rd(A_FLG, v); chk("R3 no overflow on match", v, 16'h0000);
        cap_pin = 1'b1; cycles(10);
        rd(A_FLG, v); chk("R7 no capture flag", v, 16'h0000);
        rd(A_CAP, v); chk("R7 top unchanged", v, 16'h0005);
        cap_pin = 1'b0; cycles(10);
        wr(A_CNT, 16'hFFFE);
        cycles(1); rd(A_CNT, v); chk("R3 above top runs to max", v, 16'hFFFF);
        cycles(1); rd(A_CNT, v); chk("R3 above top wraps", v, 16'h0000);
        rd(A_FLG, v); chk("R3 overflow above top", v, 16'h0002);
        wr(A_CTRL, 16'h0000);
        wr(A_FLG, 16'h0003);

        // R4 R5 R6 random polarity and filter with count value checks
        for (int it = 0; it < 24; it++) begin
            bit filt, rise;
            filt = 1'($urandom % 2);
            rise = 1'($urandom % 2);
            wr(A_CTRL, {14'd0, rise, filt});
            wr(A_FLG, 16'h0003);
            wr(A_CNT, 16'($urandom % 16'h8000));
            cycles(8);
            rd(A_CNT, c); cap_pin = 1'b1;
            cycles(10);
            rd(A_FLG, v); chk("R5 rising edge flag", v, {15'd0, rise});
            if (rise) begin
                rd(A_CAP, v); chk("R4 R6 rising capture value", v, exp_cap(c, filt));
            end
            wr(A_FLG, 16'h0003);
            rd(A_CNT, c); cap_pin = 1'b0;
            cycles(10);
            rd(A_FLG, v); chk("R5 falling edge flag", v, {15'd0, !rise});
            if (!rise) begin
                rd(A_CAP, v); chk("R5 R6 falling capture value", v, exp_cap(c, filt));
            end
        end

        finish_run();
    end

endmodule